// File: doc/BRIEF.md
# Predicated Reorder Buffer with Tag-Based Deactivation

This block is an in-order retirement buffer for an out-of-order core that runs both arms of a short forward branch at once. Each entry records whether it belongs to such a predicated region, the region's context tag, and the predicate value under which its result is valid. A front end allocates entries in program order. An issue picker offers the oldest entry still waiting to go, and execution units write back a result and a fault flag by entry index.

When a region's predicate is computed, the core broadcasts the tag and the outcome. Every entry holding that tag whose polarity disagrees with the outcome is turned off. Entries of other tags, unpredicated entries and anything younger than the region keep their state, so nothing is rolled back. Turned-off entries are never offered for issue. They still leave through retirement in order and use retire slots, but they neither write architected state nor raise their fault. A tag is reported free in the cycle its last buffered entry retires, so the front end can reuse it.

Top module: `pred_rob`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_idx` is 0, and `issue_valid`, `ret_valid` and `tag_free` are all 0.
- R2: An allocation is accepted when `alloc_valid` and `alloc_ready` are both 1. Entry indices are handed out as consecutive values modulo DEPTH. `alloc_ready` is 0 exactly while DEPTH entries are held.
- R3: `issue_valid`/`issue_idx` name the oldest held entry that has not been taken and is not deactivated. An entry taken with `issue_take` is not offered again.
- R4: A broadcast (`res_valid`, `res_tag`, `res_outcome`) deactivates every held predicated entry whose tag equals `res_tag` and whose polarity differs from `res_outcome`. Polarity 1 means the entry's result is kept when the predicate is 1. Entries of that tag with the matching polarity stay active.
- R5: A deactivated entry is never offered for issue, and this holds even in the cycle of the broadcast that deactivates it.
- R6: Unpredicated entries and entries with other tags are left unchanged by a broadcast, including entries younger than the region.
- R7: Up to RET_W entries retire per cycle, in order from the oldest. Retire slot k (bit k of the `ret_*` vectors) retires only if slots 0..k-1 also retire. An active entry needs its completion before it retires. A committing slot shows its result on `ret_data[k*DATA_W +: DATA_W]`.
- R8: A deactivated entry retires without a completion. It shows `ret_valid`=1, `ret_commit`=0 and `ret_fault`=0, even if it completed with a fault.
- R9: An active entry that completed with a fault retires with `ret_commit`=1 and `ret_fault`=1. It is the last slot that retires in that cycle.
- R10: A predicated entry not yet reached by a broadcast of its tag blocks retirement at the head until such a broadcast arrives.
- R11: `tag_free[t]` is 1 in the cycle in which a predicated entry with tag t retires and no other held predicated entry with tag t remains.
- R12: An entry allocated in the same cycle as a broadcast of its own tag is not affected by that broadcast. It stays active and unresolved until a later broadcast of its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_pred | input | 1 | New entry belongs to a predicated region |
| alloc_tag | input | TAG_W | Context tag of the new entry |
| alloc_pol | input | 1 | Predicate value under which the entry is kept |
| alloc_ready | output | 1 | Buffer can accept an entry |
| alloc_idx | output | log2(DEPTH) | Index given to the next entry |
| issue_valid | output | 1 | An entry is offered for issue |
| issue_idx | output | log2(DEPTH) | Index of the offered entry |
| issue_take | input | 1 | Offered entry is taken this cycle |
| cmpl_valid | input | 1 | Completion write-back |
| cmpl_idx | input | log2(DEPTH) | Entry being completed |
| cmpl_fault | input | 1 | Completed entry detected a fault |
| cmpl_data | input | DATA_W | Result value |
| res_valid | input | 1 | Predicate outcome broadcast |
| res_tag | input | TAG_W | Tag of the resolved region |
| res_outcome | input | 1 | Resolved predicate value |
| ret_valid | output | RET_W | Retire slot k leaves the buffer |
| ret_commit | output | RET_W | Retire slot k updates architected state |
| ret_fault | output | RET_W | Retire slot k raises its fault |
| ret_data | output | RET_W*DATA_W | Results of the retire slots |
| tag_free | output | 2**TAG_W | Tag t may be reused |

## Verification
The bench builds the buffer with DEPTH 8, RET_W 2, TAG_W 2 and DATA_W 8. The eight-entry ring wraps often and fills within a few cycles, so R2 is checked at the full boundary. With only four tags, random broadcasts hit live regions and reuse released tags often. With two retire slots, a blocking head, a dropped entry or a raised fault regularly cuts a retire group short.

// File: rtl/pred_rob_pkg.sv
// Shared types of the predicated reorder buffer.
// Assumes nothing beyond the standard language.
package pred_rob_pkg;
    // What a retire slot does with the entry it looks at this cycle
    typedef enum logic [1:0] {
        RK_WAIT   = 2'd0,  // slot does not retire
        RK_COMMIT = 2'd1,  // active, writes architected state
        RK_RAISE  = 2'd2,  // active, writes and raises its fault
        RK_DROP   = 2'd3   // deactivated, leaves silently
    } ret_kind_e;
endpackage

// File: rtl/pred_rob_deact.sv
// Tag-and-polarity match of a predicate broadcast against every entry.
// kill: entry turns inactive; settle: entry's predicate is now known.
// Assumes e_* hold the registered entry state of the current cycle.
module pred_rob_deact #(
    parameter int DEPTH = 128,
    parameter int TAG_W = 3
) (
    input  logic                         res_valid,
    input  logic [TAG_W-1:0]             res_tag,
    input  logic                         res_outcome,
    input  logic [DEPTH-1:0]             e_valid,
    input  logic [DEPTH-1:0]             e_pred,
    input  logic [DEPTH-1:0]             e_pol,
    input  logic [DEPTH-1:0][TAG_W-1:0]  e_tag,
    output logic [DEPTH-1:0]             kill,
    output logic [DEPTH-1:0]             settle
);
    // one comparator per entry
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic hit;
        assign hit       = res_valid && e_valid[i] && e_pred[i] && (e_tag[i] == res_tag);
        assign settle[i] = hit;
        assign kill[i]   = hit && (e_pol[i] != res_outcome);
    end
endmodule

// File: rtl/pred_rob_pick.sv
// Oldest-first selection over a ring starting at head.
// Assumes DEPTH is a power of two so index arithmetic wraps naturally.
module pred_rob_pick #(
    parameter int DEPTH = 128,
    parameter int IDX_W = 7
) (
    input  logic [DEPTH-1:0] req,
    input  logic [IDX_W-1:0] head,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] pos;

    // scan youngest to oldest so the oldest request wins last
    always_comb begin
        found = 1'b0;
        idx   = head;
        pos   = head;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            pos = head + IDX_W'(k);
            if (req[pos]) begin
                found = 1'b1;
                idx   = pos;
            end
        end
    end
endmodule

// File: rtl/pred_rob_retire.sv
// Decides which of the RET_W oldest entries leave this cycle and how.
// Assumes RET_W <= DEPTH and DEPTH a power of two.
module pred_rob_retire
    import pred_rob_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int RET_W = 8,
    parameter int IDX_W = 7,
    parameter int CNT_W = 8
) (
    input  logic [IDX_W-1:0]            head,
    input  logic [CNT_W-1:0]            count,
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0]            inact,
    input  logic [DEPTH-1:0]            done,
    input  logic [DEPTH-1:0]            settled,
    input  logic [DEPTH-1:0]            fault,
    output logic [RET_W-1:0]            ret_valid,
    output logic [RET_W-1:0]            ret_commit,
    output logic [RET_W-1:0]            ret_fault,
    output logic [RET_W-1:0][IDX_W-1:0] ret_idx,
    output logic [CNT_W-1:0]            ret_n
);
    logic             go;
    logic [IDX_W-1:0] pos;
    ret_kind_e        kind;

    // walk the slots in age order, stopping at the first that cannot leave
    always_comb begin
        go         = 1'b1;
        ret_n      = '0;
        ret_valid  = '0;
        ret_commit = '0;
        ret_fault  = '0;
        pos        = head;
        kind       = RK_WAIT;
        for (int k = 0; k < RET_W; k++) begin
            pos        = head + IDX_W'(k);
            ret_idx[k] = pos;
            kind       = RK_WAIT;
            if (go && (CNT_W'(k) < count) && valid[pos]) begin
                if (inact[pos])
                    kind = RK_DROP;
                else if (done[pos] && settled[pos])
                    kind = fault[pos] ? RK_RAISE : RK_COMMIT;
            end
            ret_valid[k]  = (kind != RK_WAIT);
            ret_commit[k] = (kind == RK_COMMIT) || (kind == RK_RAISE);
            ret_fault[k]  = (kind == RK_RAISE);
            go            = ret_valid[k] && (kind != RK_RAISE);
            ret_n         = ret_n + CNT_W'(ret_valid[k]);
        end
    end
endmodule

// File: rtl/pred_rob.sv
// Reorder buffer whose predicated entries are switched off by tag and
// polarity instead of being flushed. Entries live in a ring [head, head+count).
// Assumes: DEPTH is a power of two; cmpl_idx names a held entry; a tag is
// not given to a new region before tag_free reports it; a region's entries
// are all allocated before its last entry retires.
module pred_rob #(
    parameter int DEPTH  = 128,
    parameter int RET_W  = 8,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int NTAG  = 1 << TAG_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_valid,
    input  logic                    alloc_pred,
    input  logic [TAG_W-1:0]        alloc_tag,
    input  logic                    alloc_pol,
    output logic                    alloc_ready,
    output logic [IDX_W-1:0]        alloc_idx,
    output logic                    issue_valid,
    output logic [IDX_W-1:0]        issue_idx,
    input  logic                    issue_take,
    input  logic                    cmpl_valid,
    input  logic [IDX_W-1:0]        cmpl_idx,
    input  logic                    cmpl_fault,
    input  logic [DATA_W-1:0]       cmpl_data,
    input  logic                    res_valid,
    input  logic [TAG_W-1:0]        res_tag,
    input  logic                    res_outcome,
    output logic [RET_W-1:0]        ret_valid,
    output logic [RET_W-1:0]        ret_commit,
    output logic [RET_W-1:0]        ret_fault,
    output logic [RET_W*DATA_W-1:0] ret_data,
    output logic [NTAG-1:0]         tag_free
);
    // entry state
    logic [DEPTH-1:0]              e_valid, e_pred, e_pol, e_done, e_issued;
    logic [DEPTH-1:0]              e_fault, e_inact, e_settled;
    logic [DEPTH-1:0][TAG_W-1:0]   e_tag;
    logic [DEPTH-1:0][DATA_W-1:0]  e_data;
    logic [IDX_W-1:0]              head;
    logic [CNT_W-1:0]              count;

    logic [DEPTH-1:0]              kill, settle, issue_req, retiring;
    logic [RET_W-1:0][IDX_W-1:0]   ret_idx;
    logic [CNT_W-1:0]              ret_n;
    logic [NTAG-1:0]               tf_gone, tf_left;
    logic                          alloc_fire;

    assign alloc_ready = (count != CNT_W'(DEPTH));
    assign alloc_idx   = head + IDX_W'(count);
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign issue_req   = e_valid & ~e_issued & ~e_inact & ~kill;

    pred_rob_deact #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_deact (
        .res_valid(res_valid), .res_tag(res_tag), .res_outcome(res_outcome),
        .e_valid(e_valid), .e_pred(e_pred), .e_pol(e_pol), .e_tag(e_tag),
        .kill(kill), .settle(settle)
    );

    pred_rob_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
        .req(issue_req), .head(head), .found(issue_valid), .idx(issue_idx)
    );

    pred_rob_retire #(.DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ret (
        .head(head), .count(count), .valid(e_valid), .inact(e_inact),
        .done(e_done), .settled(e_settled), .fault(e_fault),
        .ret_valid(ret_valid), .ret_commit(ret_commit), .ret_fault(ret_fault),
        .ret_idx(ret_idx), .ret_n(ret_n)
    );

    // result of each retire slot
    for (genvar k = 0; k < RET_W; k++) begin : g_rdata
        assign ret_data[k*DATA_W +: DATA_W] = e_data[ret_idx[k]];
    end

    // mark the entries that leave this cycle
    always_comb begin
        retiring = '0;
        for (int k = 0; k < RET_W; k++)
            if (ret_valid[k]) retiring[ret_idx[k]] = 1'b1;
    end

    // a tag is free when one of its entries leaves and none stays behind
    always_comb begin
        tf_gone = '0;
        tf_left = '0;
        for (int t = 0; t < NTAG; t++) begin
            for (int k = 0; k < RET_W; k++)
                if (ret_valid[k] && e_pred[ret_idx[k]] && (e_tag[ret_idx[k]] == TAG_W'(t)))
                    tf_gone[t] = 1'b1;
            for (int i = 0; i < DEPTH; i++)
                if (e_valid[i] && !retiring[i] && e_pred[i] && (e_tag[i] == TAG_W'(t)))
                    tf_left[t] = 1'b1;
        end
        tag_free = tf_gone & ~tf_left;
    end

    // ring pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
        end else begin
            head  <= head + IDX_W'(ret_n);
            count <= count - ret_n + CNT_W'(alloc_fire);
        end
    end

    // per-entry state: retire, broadcast, issue, completion, then allocation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_valid   <= '0;
            e_pred    <= '0;
            e_pol     <= '0;
            e_done    <= '0;
            e_issued  <= '0;
            e_fault   <= '0;
            e_inact   <= '0;
            e_settled <= '0;
            e_tag     <= '0;
            e_data    <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (retiring[i]) e_valid[i]   <= 1'b0;
                if (kill[i])     e_inact[i]   <= 1'b1;
                if (settle[i])   e_settled[i] <= 1'b1;
                if (issue_take && issue_valid && (issue_idx == IDX_W'(i)))
                    e_issued[i] <= 1'b1;
                if (cmpl_valid && (cmpl_idx == IDX_W'(i))) begin
                    e_done[i]  <= 1'b1;
                    e_fault[i] <= cmpl_fault;
                    e_data[i]  <= cmpl_data;
                end
                if (alloc_fire && (alloc_idx == IDX_W'(i))) begin
                    e_valid[i]   <= 1'b1;
                    e_pred[i]    <= alloc_pred;
                    e_tag[i]     <= alloc_tag;
                    e_pol[i]     <= alloc_pol;
                    e_done[i]    <= 1'b0;
                    e_issued[i]  <= 1'b0;
                    e_fault[i]   <= 1'b0;
                    e_inact[i]   <= 1'b0;
                    e_settled[i] <= !alloc_pred;
                end
            end
        end
    end
endmodule

// File: rtl/pred_rob_chk.sv
// Property checker for pred_rob, attached with bind below.
// Assumes it sees the top's ports and its entry state vectors.
module pred_rob_chk #(
    parameter int DEPTH = 128,
    parameter int RET_W = 8,
    parameter int IDX_W = 7,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [RET_W-1:0] ret_valid,
    input logic [RET_W-1:0] ret_commit,
    input logic [RET_W-1:0] ret_fault,
    input logic             issue_valid,
    input logic [IDX_W-1:0] issue_idx,
    input logic             issue_take,
    input logic [DEPTH-1:0] e_valid,
    input logic [DEPTH-1:0] e_pred,
    input logic [DEPTH-1:0] e_settled,
    input logic [DEPTH-1:0] e_inact,
    input logic [IDX_W-1:0] head,
    input logic [CNT_W-1:0] count
);
    // R8: only retiring slots may commit
    a_r8_commit_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_commit & ~ret_valid) == '0);

    // R9: a raised fault belongs to a committing slot
    a_r9_fault_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_fault & ~ret_commit) == '0);

    // R7: retiring slots form a prefix of the group
    a_r7_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid & (ret_valid + RET_W'(1))) == '0);

    // R9: nothing younger retires alongside a raised fault
    a_r9_fault_last: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_fault != '0) |-> (ret_valid == ((ret_fault << 1) - RET_W'(1))));

    // R5: the picker never offers a deactivated entry
    a_r5_no_inactive_issue: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> !e_inact[issue_idx]);

    // R10: an unresolved predicated head holds retirement
    a_r10_head_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0 && e_valid[head] && e_pred[head] && !e_settled[head]) |-> (ret_valid == '0));

    // R3: a taken entry is not offered in the next cycle
    a_r3_taken_gone: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_take) |=> (!issue_valid || issue_idx != $past(issue_idx)));
endmodule

bind pred_rob pred_rob_chk #(.DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_commit(ret_commit),
    .ret_fault(ret_fault), .issue_valid(issue_valid), .issue_idx(issue_idx),
    .issue_take(issue_take), .e_valid(e_valid), .e_pred(e_pred),
    .e_settled(e_settled), .e_inact(e_inact), .head(head), .count(count)
);

// File: tb/pred_rob_test.sv
`timescale 1ns/1ps
// Bench for pred_rob: directed corner cases, then seeded random traffic,
// each cycle compared against a requirement-level model of the buffer.
module pred_rob_test;
    localparam int D  = 8;
    localparam int RW = 2;
    localparam int TW = 2;
    localparam int DW = 8;
    localparam int NT = 1 << TW;
    localparam int IW = $clog2(D);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 0, alloc_pred = 0, alloc_pol = 0;
    logic [TW-1:0] alloc_tag = '0;
    logic alloc_ready;
    logic [IW-1:0] alloc_idx, issue_idx;
    logic issue_valid, issue_take = 0;
    logic cmpl_valid = 0, cmpl_fault = 0;
    logic [IW-1:0] cmpl_idx = '0;
    logic [DW-1:0] cmpl_data = '0;
    logic res_valid = 0, res_outcome = 0;
    logic [TW-1:0] res_tag = '0;
    logic [RW-1:0] ret_valid, ret_commit, ret_fault;
    logic [RW*DW-1:0] ret_data;
    logic [NT-1:0] tag_free;

    int n_tests = 0;
    int n_fail = 0;

    pred_rob #(.DEPTH(D), .RET_W(RW), .TAG_W(TW), .DATA_W(DW)) uut (.*);

    always #10 clk = ~clk;

    // model state
    bit m_valid[D], m_pred[D], m_pol[D], m_done[D], m_issued[D];
    bit m_fault[D], m_inact[D], m_settled[D];
    int m_tag[D], m_data[D];
    int m_head, m_count;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic bit ent_kill(input int i);
        return res_valid && m_valid[i] && m_pred[i] && m_tag[i] == int'(res_tag) && m_pol[i] != res_outcome;
    endfunction

    function automatic bit ent_settle(input int i);
        return res_valid && m_valid[i] && m_pred[i] && m_tag[i] == int'(res_tag);
    endfunction

    // compare outputs of the present cycle, then advance the model by one edge
    task automatic cycle();
        bit e_iv; int e_ii; bit go; int n; bit ok; int p;
        bit rv[RW]; bit rc[RW]; bit rf[RW]; bit leave[D];
        logic [NT-1:0] e_tf;
        #2;
        chk("R2 ready", alloc_ready, m_count < D);
        chk("R2 index", alloc_idx, (m_head + m_count) % D);
        e_iv = 0; e_ii = 0;
        for (int k = D - 1; k >= 0; k--) begin
            p = (m_head + k) % D;
            if (m_valid[p] && !m_issued[p] && !m_inact[p] && !ent_kill(p)) begin e_iv = 1; e_ii = p; end
        end
        chk("R3 R5 issue_valid", issue_valid, e_iv);
        if (e_iv) chk("R3 issue_idx", issue_idx, e_ii);
        go = 1; n = 0;
        for (int i = 0; i < D; i++) leave[i] = 0;
        for (int k = 0; k < RW; k++) begin
            p = (m_head + k) % D;
            ok = go && k < m_count && m_valid[p] && (m_inact[p] || (m_done[p] && m_settled[p]));
            rv[k] = ok; rc[k] = ok && !m_inact[p]; rf[k] = rc[k] && m_fault[p];
            go = ok && !rf[k];
            if (ok) begin n++; leave[p] = 1; end
            chk("R7 R10 ret_valid", ret_valid[k], rv[k]);
            chk("R4 R6 R8 ret_commit", ret_commit[k], rc[k]);
            chk("R8 R9 ret_fault", ret_fault[k], rf[k]);
            if (rc[k]) chk("R7 ret_data", ret_data[k*DW +: DW], m_data[p]);
        end
        for (int t = 0; t < NT; t++) begin
            bit gone; bit left;
            gone = 0; left = 0;
            for (int i = 0; i < D; i++) begin
                if (leave[i] && m_pred[i] && m_tag[i] == t) gone = 1;
                if (m_valid[i] && !leave[i] && m_pred[i] && m_tag[i] == t) left = 1;
            end
            e_tf[t] = gone && !left;
        end
        chk("R11 tag_free", tag_free, e_tf);
        // state update in the order the requirements define
        for (int i = 0; i < D; i++) begin
            bit kl; bit st;
            kl = ent_kill(i); st = ent_settle(i);
            if (leave[i]) m_valid[i] = 0;
            if (kl) m_inact[i] = 1;
            if (st) m_settled[i] = 1;
            if (issue_take && e_iv && e_ii == i) m_issued[i] = 1;
            if (cmpl_valid && int'(cmpl_idx) == i) begin
                m_done[i] = 1; m_fault[i] = cmpl_fault; m_data[i] = cmpl_data;
            end
        end
        if (alloc_valid && m_count < D) begin
            p = (m_head + m_count) % D;
            m_valid[p] = 1; m_pred[p] = alloc_pred; m_tag[p] = alloc_tag; m_pol[p] = alloc_pol;
            m_done[p] = 0; m_issued[p] = 0; m_fault[p] = 0; m_inact[p] = 0;
            m_settled[p] = !alloc_pred;
            m_count++;
        end
        m_head = (m_head + n) % D;
        m_count = m_count - n;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        alloc_valid = 0; issue_take = 0; cmpl_valid = 0; res_valid = 0; cmpl_fault = 0;
    endtask

    task automatic alloc1(input bit pr, input int tg, input bit pl);
        idle_inputs();
        alloc_valid = 1; alloc_pred = pr; alloc_tag = TW'(tg); alloc_pol = pl;
        cycle();
        idle_inputs();
    endtask

    task automatic cmpl1(input int idx, input bit flt, input int dat);
        idle_inputs();
        cmpl_valid = 1; cmpl_idx = IW'(idx); cmpl_fault = flt; cmpl_data = DW'(dat);
        cycle();
        idle_inputs();
    endtask

    task automatic bcast(input int tg, input bit oc);
        idle_inputs();
        res_valid = 1; res_tag = TW'(tg); res_outcome = oc;
        cycle();
        idle_inputs();
    endtask

    // one cycle of random traffic; alloc_on lets a phase drain the buffer
    task automatic rand_cycle(input bit alloc_on);
        int r;
        alloc_valid = alloc_on && ($urandom % 10 < 6);
        alloc_pred = $urandom % 2; alloc_tag = TW'($urandom); alloc_pol = $urandom % 2;
        issue_take = ($urandom % 10) < 7;
        r = $urandom % D;
        cmpl_valid = m_valid[r] && !m_done[r] && ($urandom % 2);
        cmpl_idx = IW'(r); cmpl_fault = ($urandom % 8) == 0; cmpl_data = DW'($urandom);
        res_valid = ($urandom % 6) == 0; res_tag = TW'($urandom); res_outcome = $urandom % 2;
        cycle();
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < D; i++) begin
            m_valid[i] = 0; m_pred[i] = 0; m_pol[i] = 0; m_done[i] = 0; m_issued[i] = 0;
            m_fault[i] = 0; m_inact[i] = 0; m_settled[i] = 0; m_tag[i] = 0; m_data[i] = 0;
        end
        m_head = 0; m_count = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        // R1: empty after reset
        chk("R1 alloc_ready", alloc_ready, 1);
        chk("R1 alloc_idx", alloc_idx, 0);
        chk("R1 issue_valid", issue_valid, 0);
        chk("R1 ret_valid", ret_valid, 0);
        chk("R1 tag_free", tag_free, 0);
        @(negedge clk);

        // R4 R6 R8 R10 R11: two-armed region with a younger plain entry
        alloc1(0, 0, 0);            // e0 plain
        alloc1(1, 1, 1);            // e1 tag1 kept if 1
        alloc1(1, 1, 0);            // e2 tag1 kept if 0
        alloc1(0, 0, 0);            // e3 plain, younger
        cmpl1(0, 0, 8'h11);
        cmpl1(1, 0, 8'h22);
        cmpl1(2, 1, 8'h33);
        cmpl1(3, 0, 8'h44);
        cycle();
        #2;
        chk("R10 head waits for broadcast", ret_valid, 0);
        @(negedge clk);
        bcast(1, 1);
        repeat (3) cycle();

        // R9: active fault ends the retire group
        alloc1(0, 0, 0);
        alloc1(0, 0, 0);
        cmpl1(4, 1, 8'h55);
        cmpl1(5, 0, 8'h66);
        repeat (3) cycle();

        // R12: allocation and broadcast of the same tag in one cycle
        idle_inputs();
        alloc_valid = 1; alloc_pred = 1; alloc_tag = 2'd2; alloc_pol = 0;
        res_valid = 1; res_tag = 2'd2; res_outcome = 1;
        cycle();
        idle_inputs();
        cmpl1(6, 0, 8'h77);
        cycle();
        #2;
        chk("R12 new entry neither dropped nor retired", ret_valid, 0);
        @(negedge clk);
        bcast(2, 0);
        repeat (2) cycle();

        // R2: fill to the boundary, then drain
        for (int i = 0; i < D + 2; i++) alloc1(0, 0, 0);
        for (int i = 0; i < 60; i++) rand_cycle(0);

        // random traffic
        for (int i = 0; i < 4000; i++) rand_cycle(1);
        for (int i = 0; i < 200; i++) rand_cycle(0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule